// File: doc/BRIEF.md
# Hybrid stochastic-binary recurrent neuron

This block is a single neuron for a ring-shaped recurrent network. The weighted sum is formed in stochastic logic and the activation in ordinary binary logic. It takes two signed operands, an external input and a value from a neighbouring neuron, together with one weight for each. All four are binary codes in shifted (offset) form. Each code becomes a bitstream by comparison against a random word that the surrounding chip supplies fresh every cycle. A single gate multiplies each operand stream by its weight stream. A selector that alternates every cycle averages the two product streams.

A window counter counts the HIGH bits of the averaged stream over 2^CNT_W cycles, which recovers a binary estimate of half the weighted sum. A three-segment piecewise-linear stand-in for the hyperbolic tangent shapes that estimate. The result is registered as the neuron's state for the next time step. A one-cycle strobe marks each new state. The state uses the same shifted code as the operands, so a neighbour can take it directly as its `x_nbr_i`.

Top module: `hsb_neuron`

## Requirements
- R1: Each operand and weight bit in a cycle is 1 exactly when its DATA_W-bit code is strictly greater than the random word supplied for it in that cycle (equality gives 0).
- R2: Codes are bipolar: code c stands for the real value 2c/2^DATA_W - 1. The product stream of an operand and its weight is the XNOR of the two bits.
- R3: Window cycles are numbered 0 to 2^CNT_W-1 from the window start. The averaged stream takes the external product on even-numbered cycles and the neighbour product on odd-numbered cycles.
- R4: A window lasts exactly 2^CNT_W cycles. The state `y_o` changes only at the last edge of a window, and `step_o` is high for exactly the one cycle that follows that edge.
- R5: The sum S is the number of HIGH bits of the averaged stream in a window, clamped at 2^CNT_W-1. A window that is HIGH in every cycle therefore yields S = 2^CNT_W-1 and does not wrap.
- R6: When S < 2^(CNT_W-2), which means a pre-activation at or below -1, the new state is 0 (real value -1).
- R7: When S >= 3·2^(CNT_W-2), which means a pre-activation at or above +1, the new state is 2^DATA_W-1 (largest positive code).
- R8: Otherwise the new state is S·2^(DATA_W+1-CNT_W) - 2^(DATA_W-1). This is slope 1 in real terms after the halving by the averaging is undone, and its sign bit is set exactly when S >= 2^(CNT_W-1).
- R9: Between updates the state and the strobe hold: `y_o` is stable and `step_o` is low in every cycle of a window except the first.
- R10: While `rst_n` is low, `y_o` is 2^(DATA_W-1) (real zero) and `step_o` is 0. After `rst_n` rises, two clock edges resynchronise reset, and the first window begins on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| x_ext_i | input | DATA_W | External operand, shifted bipolar code |
| w_ext_i | input | DATA_W | Weight of the external operand |
| x_nbr_i | input | DATA_W | Neighbour neuron state, shifted bipolar code |
| w_nbr_i | input | DATA_W | Weight of the neighbour operand |
| rnd_x_ext_i | input | DATA_W | Random word for the external operand stream |
| rnd_w_ext_i | input | DATA_W | Random word for the external weight stream |
| rnd_x_nbr_i | input | DATA_W | Random word for the neighbour operand stream |
| rnd_w_nbr_i | input | DATA_W | Random word for the neighbour weight stream |
| y_o | output | DATA_W | Registered neuron state |
| step_o | output | 1 | One-cycle strobe after each state update |

## Verification
The assertions assume that operands and weights stay constant for a whole window and are never unknown. They also assume the random words are defined in every cycle. The window-monotonic check on the ones counter depends on the window counter starting at zero after reset. The stimulus therefore changes operands only at window boundaries and drives every random word on each falling edge. It uses either fresh random words or a fixed word chosen to force a stream fully on or fully off. Those fixed words reach the clamp, the saturation, the exact midpoint and the strict-comparison corner.

// File: rtl/hsb_neuron_pkg.sv
package hsb_neuron_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_CNT_W  = 10;

  typedef enum logic [1:0] {
    SEG_LOW  = 2'd0,
    SEG_LIN  = 2'd1,
    SEG_HIGH = 2'd2
  } seg_e;

  typedef enum logic [1:0] {
    OPD_X_EXT = 2'd0,
    OPD_W_EXT = 2'd1,
    OPD_X_NBR = 2'd2,
    OPD_W_NBR = 2'd3
  } opd_e;
endpackage

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] code_i,
  input  logic [DATA_W-1:0] rnd_i,
  output logic              bit_o
);
  always_comb begin
    bit_o = (code_i > rnd_i);
  end

  // R1: a zero code can never exceed any random word
  always_comb begin
    if (!$isunknown(code_i) && !$isunknown(bit_o)) begin
      p_zero_code_r1: assert (!((code_i == '0) && bit_o))
        else $error("zero code produced a HIGH bit");
    end
  end
endmodule

// File: rtl/sc_mul_add.sv
module sc_mul_add (
  input  logic [3:0] bits_i,
  input  logic       sel_i,
  output logic       bit_o
);
  import hsb_neuron_pkg::*;

  logic prod_ext;
  logic prod_nbr;

  always_comb begin
    prod_ext = ~(bits_i[OPD_X_EXT] ^ bits_i[OPD_W_EXT]);
    prod_nbr = ~(bits_i[OPD_X_NBR] ^ bits_i[OPD_W_NBR]);
    bit_o    = sel_i ? prod_nbr : prod_ext;
  end
endmodule

// File: rtl/sc_p2b.sv
module sc_p2b #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output logic             sel_o,
  output logic             done_o,
  output logic [CNT_W-1:0] sum_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] ones_q, ones_d;
  logic [CNT_W-1:0] ones_inc;
  logic [CNT_W-1:0] total;
  logic             last;
  logic             ones_en;

  always_comb begin
    last     = (win_q == ALL_ONES);
    win_d    = win_q + 1'b1;
    ones_inc = (ones_q == ALL_ONES) ? ones_q : ones_q + 1'b1;
    total    = bit_i ? ones_inc : ones_q;
    ones_d   = last ? '0 : total;
    ones_en  = bit_i | last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (ones_en) begin
      ones_q <= ones_d;
    end
  end

  always_comb begin
    sel_o  = win_q[0];
    done_o = last;
    sum_o  = total;
  end

  // R5: within a window the HIGH count never goes backwards (no wrap)
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> (ones_q >= $past(ones_q)))
    else $error("ones counter wrapped inside a window");

  // R4: a fresh window always starts from an empty count
  p_window_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0) |-> (ones_q == '0))
    else $error("window started with a stale count");
endmodule

// File: rtl/pwl_tanh.sv
module pwl_tanh #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input  logic [CNT_W-1:0]  sum_i,
  output logic [DATA_W-1:0] act_o
);
  import hsb_neuron_pkg::*;

  localparam int unsigned SHIFT = DATA_W + 1 - CNT_W;
  localparam logic [CNT_W-1:0] QUARTER  = CNT_W'(1) << (CNT_W - 2);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] THREE_Q  = QUARTER + HALF;
  localparam logic [DATA_W:0]  OFFSET   = (DATA_W+1)'(1) << (DATA_W - 1);

  seg_e            seg;
  logic [DATA_W:0] scaled;
  logic [DATA_W:0] lin;

  always_comb begin
    if (sum_i < QUARTER) begin
      seg = SEG_LOW;
    end else if (sum_i >= THREE_Q) begin
      seg = SEG_HIGH;
    end else begin
      seg = SEG_LIN;
    end
    scaled = (DATA_W+1)'(sum_i) << SHIFT;
    lin    = scaled - OFFSET;
    case (seg)
      SEG_LOW:  act_o = '0;
      SEG_HIGH: act_o = '1;
      default:  act_o = lin[DATA_W-1:0];
    endcase
  end

  // R8: sign of the result follows which half of the window count it is in
  always_comb begin
    if (!$isunknown(sum_i)) begin
      p_sign_r8: assert (act_o[DATA_W-1] == (sum_i >= HALF))
        else $error("activation sign disagrees with sum");
    end
  end
endmodule

// File: rtl/hsb_neuron.sv
module hsb_neuron #(
  parameter int unsigned DATA_W = hsb_neuron_pkg::DEF_DATA_W,
  parameter int unsigned CNT_W  = hsb_neuron_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_ext_i,
  input  logic [DATA_W-1:0] w_ext_i,
  input  logic [DATA_W-1:0] x_nbr_i,
  input  logic [DATA_W-1:0] w_nbr_i,
  input  logic [DATA_W-1:0] rnd_x_ext_i,
  input  logic [DATA_W-1:0] rnd_w_ext_i,
  input  logic [DATA_W-1:0] rnd_x_nbr_i,
  input  logic [DATA_W-1:0] rnd_w_nbr_i,
  output logic [DATA_W-1:0] y_o,
  output logic              step_o
);
  localparam int unsigned     N_OPD    = 4;
  localparam logic [DATA_W-1:0] Y_RESET = DATA_W'(1) << (DATA_W - 1);

  logic                    rst_meta_q;
  logic                    rst_sync_q;
  logic [DATA_W-1:0]       codes [N_OPD];
  logic [DATA_W-1:0]       rnds  [N_OPD];
  logic [N_OPD-1:0]        opd_bits;
  logic                    sel;
  logic                    avg_bit;
  logic                    done;
  logic [CNT_W-1:0]        sum;
  logic [DATA_W-1:0]       act;
  logic [DATA_W-1:0]       y_q, y_d;
  logic                    step_q, step_d;
  logic                    y_en;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    codes[0] = x_ext_i;
    codes[1] = w_ext_i;
    codes[2] = x_nbr_i;
    codes[3] = w_nbr_i;
    rnds[0]  = rnd_x_ext_i;
    rnds[1]  = rnd_w_ext_i;
    rnds[2]  = rnd_x_nbr_i;
    rnds[3]  = rnd_w_nbr_i;
  end

  for (genvar g = 0; g < N_OPD; g++) begin : g_enc
    sc_stream_gen #(.DATA_W(DATA_W)) u_enc (
      .code_i (codes[g]),
      .rnd_i  (rnds[g]),
      .bit_o  (opd_bits[g])
    );
  end

  sc_mul_add u_mul_add (
    .bits_i (opd_bits),
    .sel_i  (sel),
    .bit_o  (avg_bit)
  );

  sc_p2b #(.CNT_W(CNT_W)) u_p2b (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .bit_i  (avg_bit),
    .sel_o  (sel),
    .done_o (done),
    .sum_o  (sum)
  );

  pwl_tanh #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_act (
    .sum_i (sum),
    .act_o (act)
  );

  always_comb begin
    y_en   = done;
    y_d    = act;
    step_d = done;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      y_q <= Y_RESET;
    end else if (y_en) begin
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      step_q <= 1'b0;
    end else begin
      step_q <= step_d;
    end
  end

  assign y_o    = y_q;
  assign step_o = step_q;

  // R9: the state moves only on the edge that raises the strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !step_q |-> $stable(y_q))
    else $error("state changed outside an update");

  // R4: the strobe never lasts two cycles
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    step_q |=> !step_q)
    else $error("strobe held for more than one cycle");
endmodule

// File: tb/tb_hsb_neuron.sv
`timescale 1ns/1ps
module tb_hsb_neuron;
  localparam int unsigned DW  = 16;
  localparam int unsigned CW  = 10;
  localparam int unsigned WIN = 1 << CW;
  localparam int unsigned NV  = 8;

  // entry: x_ext, w_ext, x_nbr, w_nbr, use-fixed-random flag, fixed random word
  localparam logic [80:0] VEC [NV] = '{
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000},
    {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 16'h0000},
    {16'h1234, 16'hFFFF, 16'h1234, 16'hFFFF, 1'b1, 16'h1234},
    {16'hC000, 16'hE000, 16'h9000, 16'h6000, 1'b0, 16'h0000},
    {16'h2000, 16'hD000, 16'hF000, 16'h3000, 1'b0, 16'h0000},
    {16'hF000, 16'hF000, 16'hE800, 16'hF800, 1'b0, 16'h0000},
    {16'h8000, 16'h8000, 16'hB000, 16'hA000, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] x_ext, w_ext, x_nbr, w_nbr;
  logic [DW-1:0] r_xe, r_we, r_xn, r_wn;
  logic [DW-1:0] y;
  logic          step;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  hsb_neuron #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .x_ext_i(x_ext), .w_ext_i(w_ext), .x_nbr_i(x_nbr), .w_nbr_i(w_nbr),
    .rnd_x_ext_i(r_xe), .rnd_w_ext_i(r_we), .rnd_x_nbr_i(r_xn), .rnd_w_nbr_i(r_wn),
    .y_o(y), .step_o(step)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_act(input int unsigned s);
    if (s < WIN / 4) return '0;
    if (s >= 3 * WIN / 4) return '1;
    return DW'(s * (1 << (DW + 1 - CW)) - (1 << (DW - 1)));
  endfunction

  // one full window; starts on a falling edge, ends on the falling edge after the last update
  task automatic run_window(input logic [80:0] v, input string tag);
    int unsigned s = 0;
    logic [DW-1:0] y_before = y;
    x_ext = v[80:65]; w_ext = v[64:49]; x_nbr = v[48:33]; w_nbr = v[32:17];
    for (int k = 0; k < int'(WIN); k++) begin
      logic be, bw, bn, bm, pe, pn, b;
      if (v[16]) begin
        r_xe = v[15:0]; r_we = v[15:0]; r_xn = v[15:0]; r_wn = v[15:0];
      end else begin
        r_xe = DW'($urandom); r_we = DW'($urandom);
        r_xn = DW'($urandom); r_wn = DW'($urandom);
      end
      be = x_ext > r_xe; bw = w_ext > r_we;   // R1
      bn = x_nbr > r_xn; bm = w_nbr > r_wn;
      pe = ~(be ^ bw); pn = ~(bn ^ bm);       // R2
      b  = k[0] ? pn : pe;                    // R3
      if (b && s < WIN - 1) s++;              // R5
      if (k == int'(WIN) / 2) begin
        chk({tag, " R9 state held mid-window"}, 32'(y), 32'(y_before));
        chk({tag, " R4 strobe low mid-window"}, 32'(step), 32'd0);
      end
      @(negedge clk);
    end
    chk({tag, " R8 state after window"}, 32'(y), 32'(model_act(s)));
    chk({tag, " R4 strobe after window"}, 32'(step), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    x_ext = '0; w_ext = '0; x_nbr = '0; w_nbr = '0;
    r_xe = '0; r_we = '0; r_xn = '0; r_wn = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", 32'(y), 32'h8000);
    chk("R10 reset strobe", 32'(step), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 state held during resync", 32'(y), 32'h8000);

    for (int i = 0; i < int'(NV); i++) begin
      run_window(VEC[i], $sformatf("vec%0d", i));
    end

    // R5: all-HIGH window saturates at 2^CW-1 instead of wrapping to zero
    run_window({16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0000}, "R5 saturate");
    chk("R5 R7 all-high window clamps to top code", 32'(y), 32'hFFFF);
    // R6: all-LOW window gives the lowest code
    run_window({16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 16'h0000}, "R6 floor");
    chk("R6 all-low window gives zero code", 32'(y), 32'h0000);
    // R3: external product HIGH on even cycles only gives the exact midpoint
    run_window({16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 16'h0000}, "R3 parity");
    chk("R3 R8 half-high window gives midpoint", 32'(y), 32'h8000);
    // R1: equal code and random word gives 0, so products are 0
    run_window({16'h1234, 16'hFFFF, 16'h1234, 16'hFFFF, 1'b1, 16'h1234}, "R1 equal");
    chk("R1 equality gives LOW bit", 32'(y), 32'h0000);

    // R10: reset in mid-run restores zero state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset state", 32'(y), 32'h8000);
    chk("R10 mid-run reset strobe", 32'(step), 32'd0);
    rst_n = 1'b1;

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule